// File: doc/BRIEF.md
# DDR2 Command Spacing Monitor

This block sits beside a DDR2 memory controller and watches the decoded command stream on the controller clock. Each cycle it sees one operation (idle, row open, column read, column write, row close, refresh), a bank number and an auto-close flag. It flags any command that arrives before the device is ready to accept it. It never drives the memory and never stalls the controller. It keeps per-bank countdown timers for row-open-to-column, row-close-to-reopen and column-to-close spacing. It also keeps device-wide timers for open-to-open spacing across banks, column-to-column spacing and write-to-read turnaround.

All limits are parameters. Nanosecond limits are given in picoseconds and turned into clock cycles by rounding up against the clock period parameter. A profile parameter picks the faster or the slower speed grade for the two limits that differ between them. Write-side limits count from the end of the write burst, which lies a write latency plus a burst length in cycles after the write command.

When a rule is broken the monitor raises a one-cycle pulse and latches a sticky flag with a 4-bit code that names the first rule that broke. An illegal command leaves the device in an undefined state, so the flag holds until reset.

Top module: `ddr2_cmd_guard`

## Requirements
- R1: While reset is high and right after it, violFlag, violPulse and violCode are all zero.
- R2: A READ or WRITE to an open bank fewer than ceil(T_RCD_PS/CLK_PS) cycles after that bank's ACTIVATE is a violation with code 1. This holds with or without auto-close.
- R3: An ACTIVATE to a bank fewer than ceil(T_RP_PS/CLK_PS) cycles after a PRECHARGE of that open bank is a violation with code 2. The same code applies fewer than RTP plus RP cycles after a READ with auto-close to that bank.
- R4: An ACTIVATE to a bank other than the previously activated one, fewer than the RRD cycles after that ACTIVATE, is a violation with code 3. RRD is ceil of 7500 ps when FAST_GRADE is 1 and ceil of 10000 ps when it is 0.
- R5: A READ or WRITE fewer than CCD_CK cycles after any earlier READ or WRITE is a violation with code 4.
- R6: A PRECHARGE to an open bank before WRITE_LAT+BURST_CK+ceil(T_WR_PS/CLK_PS) cycles have passed since a WRITE to that bank is a violation with code 5.
- R7: A READ before WRITE_LAT+BURST_CK+WTR cycles have passed since any WRITE is a violation with code 6. WTR is ceil of 7500 ps in the fast profile and ceil of 10000 ps in the slow one.
- R8: A PRECHARGE to an open bank fewer than ceil(T_RTP_PS/CLK_PS) cycles after a READ to that bank is a violation with code 7.
- R9: After a WRITE with auto-close, an ACTIVATE to that bank before WRITE_LAT+BURST_CK+WR+RP cycles is a violation with code 8.
- R10: A READ or WRITE to a closed bank, or an ACTIVATE to an open bank, is a violation with code 9. A PRECHARGE to a closed bank is ignored.
- R11: Each violating command gives violPulse high for exactly the next cycle. violFlag and violCode latch on the first violation and hold through later violations until reset.
- R12: When one command breaks several rules, code 9 wins; otherwise the lowest code wins.
- R13: cmdOp encodes 0 idle, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH. Idle and REFRESH never flag. A command issued exactly at its limit does not flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdOp | input | 3 | Decoded command code |
| cmdBank | input | BANK_W | Bank addressed by the command |
| cmdAutoPre | input | 1 | Auto-close flag for READ and WRITE |
| violPulse | output | 1 | One-cycle pulse after each violating command |
| violFlag | output | 1 | Sticky violation flag |
| violCode | output | 4 | Code of the first violation, 0 while none |

## Verification
Directed sequences put the second command of each rule one cycle before and exactly at its limit. Each pair separates an off-by-one in the cycle conversion from a missing rule. Commands that break two rules at once tell whether the priority is right. A second violation after the first tells whether the code stays sticky while the pulse repeats. Random streams mix all six commands over four banks with auto-close toggled. They are compared against a timestamp model, which exposes wrong per-bank isolation and wrong max-merging of overlapping limits.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5
  } opE;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic autoPre;
  } guardStbT;

  function automatic int psToCk(input int ps, input int clkPs);
    return (ps + clkPs - 1) / clkPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_guard_timers.sv
module ddr2_guard_timers
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int C_RCD     = 4,
  parameter int C_RP      = 4,
  parameter int C_RRD     = 2,
  parameter int C_CCD     = 2,
  parameter int C_WR      = 4,
  parameter int C_WTR     = 2,
  parameter int C_RTP     = 2,
  parameter int W_DATA    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  guardStbT             stb,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] rcdBusy,
  output logic [NUM_BANKS-1:0] actBusy,
  output logic [NUM_BANKS-1:0] actIsDal,
  output logic [NUM_BANKS-1:0] preBusy,
  output logic [NUM_BANKS-1:0] preIsWr,
  output logic                 rrdBusy,
  output logic [BANK_W-1:0]    lastActBank,
  output logic                 ccdBusy,
  output logic                 wtrBusy
);

  localparam int MAX_LD = maxOf(maxOf(W_DATA + C_WR + C_RP, C_RTP + C_RP),
                                maxOf(C_RCD, W_DATA + C_WTR));
  localparam int CNT_W  = $clog2(MAX_LD + 1);

  localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(C_RCD - 1);
  localparam logic [CNT_W-1:0] L_RP   = CNT_W'(C_RP - 1);
  localparam logic [CNT_W-1:0] L_RDAP = CNT_W'(C_RTP + C_RP - 1);
  localparam logic [CNT_W-1:0] L_DAL  = CNT_W'(W_DATA + C_WR + C_RP - 1);
  localparam logic [CNT_W-1:0] L_WR   = CNT_W'(W_DATA + C_WR - 1);
  localparam logic [CNT_W-1:0] L_RTP  = CNT_W'(C_RTP - 1);
  localparam logic [CNT_W-1:0] L_RRD  = CNT_W'(C_RRD - 1);
  localparam logic [CNT_W-1:0] L_CCD  = CNT_W'(C_CCD - 1);
  localparam logic [CNT_W-1:0] L_WTR  = CNT_W'(W_DATA + C_WTR - 1);

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic             sel;
    logic [CNT_W-1:0] rcdCnt, actCnt, preCnt;
    logic             isOpen, dalTag, wrTag;
    logic             actLd, actLdDal;
    logic [CNT_W-1:0] actLdVal;

    assign sel = (bank == BANK_W'(b));

    always_comb begin
      actLd    = 1'b0;
      actLdDal = 1'b0;
      actLdVal = '0;
      if (sel && stb.pre) begin
        actLd = 1'b1; actLdVal = L_RP;
      end else if (sel && stb.rd && stb.autoPre) begin
        actLd = 1'b1; actLdVal = L_RDAP;
      end else if (sel && stb.wr && stb.autoPre) begin
        actLd = 1'b1; actLdVal = L_DAL; actLdDal = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rcdCnt <= '0;
        actCnt <= '0;
        preCnt <= '0;
        isOpen <= 1'b0;
        dalTag <= 1'b0;
        wrTag  <= 1'b0;
      end else begin
        rcdCnt <= (sel && stb.act) ? L_RCD : dec(rcdCnt);
        if (actLd && actLdVal > dec(actCnt)) begin
          actCnt <= actLdVal;
          dalTag <= actLdDal;
        end else begin
          actCnt <= dec(actCnt);
        end
        if (sel && stb.rd && L_RTP > dec(preCnt)) begin
          preCnt <= L_RTP;
          wrTag  <= 1'b0;
        end else if (sel && stb.wr && L_WR > dec(preCnt)) begin
          preCnt <= L_WR;
          wrTag  <= 1'b1;
        end else begin
          preCnt <= dec(preCnt);
        end
        if (sel && stb.act)
          isOpen <= 1'b1;
        else if (sel && (stb.pre || ((stb.rd || stb.wr) && stb.autoPre)))
          isOpen <= 1'b0;
      end
    end

    assign bankOpen[b] = isOpen;
    assign rcdBusy[b]  = |rcdCnt;
    assign actBusy[b]  = |actCnt;
    assign actIsDal[b] = dalTag;
    assign preBusy[b]  = |preCnt;
    assign preIsWr[b]  = wrTag;
  end

  logic [CNT_W-1:0] rrdCnt, ccdCnt, wtrCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrdCnt      <= '0;
      ccdCnt      <= '0;
      wtrCnt      <= '0;
      lastActBank <= '0;
    end else begin
      if (stb.act) begin
        rrdCnt      <= L_RRD;
        lastActBank <= bank;
      end else begin
        rrdCnt <= dec(rrdCnt);
      end
      ccdCnt <= (stb.rd || stb.wr) ? L_CCD : dec(ccdCnt);
      wtrCnt <= (stb.wr && L_WTR > dec(wtrCnt)) ? L_WTR : dec(wtrCnt);
    end
  end

  assign rrdBusy = |rrdCnt;
  assign ccdBusy = |ccdCnt;
  assign wtrBusy = |wtrCnt;

endmodule

// File: rtl/ddr2_guard_ctrl.sv
module ddr2_guard_ctrl
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmdOp,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdAutoPre,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] rcdBusy,
  input  logic [NUM_BANKS-1:0] actBusy,
  input  logic [NUM_BANKS-1:0] actIsDal,
  input  logic [NUM_BANKS-1:0] preBusy,
  input  logic [NUM_BANKS-1:0] preIsWr,
  input  logic                 rrdBusy,
  input  logic [BANK_W-1:0]    lastActBank,
  input  logic                 ccdBusy,
  input  logic                 wtrBusy,
  output guardStbT             stb,
  output logic                 violPulse,
  output logic                 violFlag,
  output logic [3:0]           violCode
);

  logic isAct, isRd, isWr, isPre, isCol, open;
  logic [9:1] hit;
  logic [3:0] selCode;

  assign isAct = (cmdOp == OP_ACT);
  assign isRd  = (cmdOp == OP_RD);
  assign isWr  = (cmdOp == OP_WR);
  assign isPre = (cmdOp == OP_PRE);
  assign isCol = isRd || isWr;
  assign open  = bankOpen[cmdBank];

  // a close of an already closed bank is a no-op for the device
  assign stb = '{act: isAct, rd: isRd, wr: isWr, pre: isPre && open,
                 autoPre: cmdAutoPre};

  always_comb begin
    hit[9] = (isAct && open) || (isCol && !open);
    hit[1] = isCol && rcdBusy[cmdBank];
    hit[2] = isAct && actBusy[cmdBank] && !actIsDal[cmdBank];
    hit[3] = isAct && rrdBusy && (cmdBank != lastActBank);
    hit[4] = isCol && ccdBusy;
    hit[5] = isPre && open && preBusy[cmdBank] && preIsWr[cmdBank];
    hit[6] = isRd && wtrBusy;
    hit[7] = isPre && open && preBusy[cmdBank] && !preIsWr[cmdBank];
    hit[8] = isAct && actBusy[cmdBank] && actIsDal[cmdBank];
  end

  always_comb begin
    selCode = 4'd0;
    for (int c = 8; c >= 1; c--)
      if (hit[c]) selCode = 4'(c);
    if (hit[9]) selCode = 4'd9;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      violPulse <= 1'b0;
      violFlag  <= 1'b0;
      violCode  <= 4'd0;
    end else begin
      violPulse <= |hit;
      if (!violFlag && |hit) begin
        violFlag <= 1'b1;
        violCode <= selCode;
      end
    end
  end

endmodule

// File: rtl/ddr2_cmd_guard.sv
module ddr2_cmd_guard
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int CLK_PS     = 3750,
  parameter int FAST_GRADE = 1,
  parameter int WRITE_LAT  = 3,
  parameter int BURST_CK   = 2,
  parameter int CCD_CK     = 2,
  parameter int T_RCD_PS   = 15000,
  parameter int T_RP_PS    = 15000,
  parameter int T_WR_PS    = 15000,
  parameter int T_RTP_PS   = 7500,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdAutoPre,
  output logic              violPulse,
  output logic              violFlag,
  output logic [3:0]        violCode
);

  localparam int T_RRD_PS = (FAST_GRADE != 0) ? 7500 : 10000;
  localparam int T_WTR_PS = (FAST_GRADE != 0) ? 7500 : 10000;

  guardStbT             stb;
  logic [NUM_BANKS-1:0] bankOpen, rcdBusy, actBusy, actIsDal, preBusy, preIsWr;
  logic                 rrdBusy, ccdBusy, wtrBusy;
  logic [BANK_W-1:0]    lastActBank;

  ddr2_guard_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdAutoPre(cmdAutoPre), .bankOpen(bankOpen), .rcdBusy(rcdBusy),
    .actBusy(actBusy), .actIsDal(actIsDal), .preBusy(preBusy),
    .preIsWr(preIsWr), .rrdBusy(rrdBusy), .lastActBank(lastActBank),
    .ccdBusy(ccdBusy), .wtrBusy(wtrBusy), .stb(stb),
    .violPulse(violPulse), .violFlag(violFlag), .violCode(violCode)
  );

  ddr2_guard_timers #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
    .C_RCD(psToCk(T_RCD_PS, CLK_PS)), .C_RP(psToCk(T_RP_PS, CLK_PS)),
    .C_RRD(psToCk(T_RRD_PS, CLK_PS)), .C_CCD(CCD_CK),
    .C_WR(psToCk(T_WR_PS, CLK_PS)), .C_WTR(psToCk(T_WTR_PS, CLK_PS)),
    .C_RTP(psToCk(T_RTP_PS, CLK_PS)), .W_DATA(WRITE_LAT + BURST_CK)
  ) u_timers (
    .clk(clk), .rst(rst), .stb(stb), .bank(cmdBank), .bankOpen(bankOpen),
    .rcdBusy(rcdBusy), .actBusy(actBusy), .actIsDal(actIsDal),
    .preBusy(preBusy), .preIsWr(preIsWr), .rrdBusy(rrdBusy),
    .lastActBank(lastActBank), .ccdBusy(ccdBusy), .wtrBusy(wtrBusy)
  );

endmodule

// File: rtl/ddr2_cmd_guard_chk.sv
module ddr2_cmd_guard_chk #(
  parameter int BANK_W = 2,
  parameter int CCD_CK = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmdOp,
  input logic [BANK_W-1:0] cmdBank,
  input logic              violPulse,
  input logic              violFlag,
  input logic [3:0]        violCode
);

  logic colNow, actNow, quietNow;
  assign colNow   = (cmdOp == 3'd2) || (cmdOp == 3'd3);
  assign actNow   = (cmdOp == 3'd1);
  assign quietNow = (cmdOp == 3'd0) || (cmdOp == 3'd5);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!violFlag && !violPulse && violCode == 4'd0)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    violFlag |=> violFlag); // R11

  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    violFlag |=> $stable(violCode)); // R11

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    violPulse |-> violFlag); // R11

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    violFlag |-> (violCode >= 4'd1 && violCode <= 4'd9)); // R12

  AST_COL_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (CCD_CK >= 2 && colNow && $past(colNow)) |=> violPulse); // R5

  AST_REOPEN_SAME_BANK: assert property (@(posedge clk) disable iff (rst)
    (actNow && $past(actNow) && cmdBank == $past(cmdBank)) |=> violPulse); // R10

  AST_QUIET_CMD: assert property (@(posedge clk) disable iff (rst)
    quietNow |=> !violPulse); // R13

endmodule

bind ddr2_cmd_guard ddr2_cmd_guard_chk #(.BANK_W(BANK_W), .CCD_CK(CCD_CK)) u_chk (
  .clk(clk), .rst(rst), .cmdOp(cmdOp), .cmdBank(cmdBank),
  .violPulse(violPulse), .violFlag(violFlag), .violCode(violCode)
);

// File: tb/sim_ddr2_cmd_guard.sv
module sim_ddr2_cmd_guard;

  localparam int NB     = 4;
  localparam int CLKPS  = 3750;
  localparam int FAST   = 1;
  localparam int WLAT   = 3;
  localparam int BCK    = 2;
  localparam int CCD    = 2;

  function automatic int ck(input int ps);
    return (ps + CLKPS - 1) / CLKPS;
  endfunction

  localparam int WD = WLAT + BCK;

  int cRCD, cRP, cRRD, cWR, cWTR, cRTP;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cmdOp;
  logic [1:0] cmdBank;
  logic       cmdAutoPre;
  logic       violPulse, violFlag;
  logic [3:0] violCode;

  always #5 clk = ~clk;

  ddr2_cmd_guard #(.NUM_BANKS(NB), .CLK_PS(CLKPS), .FAST_GRADE(FAST),
                   .WRITE_LAT(WLAT), .BURST_CK(BCK), .CCD_CK(CCD)) u0 (
    .clk(clk), .rst(rst), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdAutoPre(cmdAutoPre), .violPulse(violPulse), .violFlag(violFlag),
    .violCode(violCode)
  );

  int nRun = 0, nFail = 0;
  int cyc;
  bit mOpen [NB];
  int rCol [NB], rAct [NB], aCode [NB], rPre [NB], pCode [NB];
  int lastAct, lastActBank, rColAny, rRead;
  bit mFlag;
  int mCode;

  function automatic string reqOf(input int c);
    case (c)
      1: return "R2";  2: return "R3";  3: return "R4";  4: return "R5";
      5: return "R6";  6: return "R7";  7: return "R8";  8: return "R9";
      9: return "R10"; default: return "R13";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expCode(input int op, input int b);
    bit h [10];
    int r;
    for (int i = 0; i < 10; i++) h[i] = 0;
    if (op == 1) begin
      if (mOpen[b]) h[9] = 1;
      if (cyc < rAct[b]) h[aCode[b]] = 1;
      if (b != lastActBank && cyc < lastAct + cRRD) h[3] = 1;
    end else if (op == 2 || op == 3) begin
      if (!mOpen[b]) h[9] = 1;
      if (cyc < rCol[b]) h[1] = 1;
      if (cyc < rColAny) h[4] = 1;
      if (op == 2 && cyc < rRead) h[6] = 1;
    end else if (op == 4) begin
      if (mOpen[b] && cyc < rPre[b]) h[pCode[b]] = 1;
    end
    r = 0;
    for (int i = 8; i >= 1; i--) if (h[i]) r = i;
    if (h[9]) r = 9;
    return r;
  endfunction

  task automatic modelUpdate(input int op, input int b, input bit ap);
    if (op == 1) begin
      mOpen[b] = 1; rCol[b] = cyc + cRCD; lastAct = cyc; lastActBank = b;
    end else if (op == 2) begin
      rColAny = cyc + CCD;
      if (cyc + cRTP > rPre[b]) begin rPre[b] = cyc + cRTP; pCode[b] = 7; end
      if (ap) begin
        mOpen[b] = 0;
        if (cyc + cRTP + cRP > rAct[b]) begin rAct[b] = cyc + cRTP + cRP; aCode[b] = 2; end
      end
    end else if (op == 3) begin
      rColAny = cyc + CCD;
      if (cyc + WD + cWTR > rRead) rRead = cyc + WD + cWTR;
      if (cyc + WD + cWR > rPre[b]) begin rPre[b] = cyc + WD + cWR; pCode[b] = 5; end
      if (ap) begin
        mOpen[b] = 0;
        if (cyc + WD + cWR + cRP > rAct[b]) begin rAct[b] = cyc + WD + cWR + cRP; aCode[b] = 8; end
      end
    end else if (op == 4 && mOpen[b]) begin
      mOpen[b] = 0;
      if (cyc + cRP > rAct[b]) begin rAct[b] = cyc + cRP; aCode[b] = 2; end
    end
  endtask

  task automatic doReset();
    rst = 1'b1; cmdOp = 3'd0; cmdBank = 2'd0; cmdAutoPre = 1'b0;
    repeat (3) @(negedge clk);
    check(!violFlag && !violPulse && violCode == 4'd0, "R1",
          {violFlag, violPulse, violCode}, 0);
    rst = 1'b0;
    cyc = 0; lastAct = -100; lastActBank = 0; rColAny = 0; rRead = 0;
    mFlag = 0; mCode = 0;
    for (int i = 0; i < NB; i++) begin
      mOpen[i] = 0; rCol[i] = 0; rAct[i] = 0; aCode[i] = 2; rPre[i] = 0; pCode[i] = 7;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic issue(input int op, input int b, input bit ap);
    int e;
    cmdOp = 3'(op); cmdBank = 2'(b); cmdAutoPre = ap;
    e = expCode(op, b);
    @(posedge clk); #1;
    check(violPulse == (e != 0), reqOf(e), violPulse, (e != 0));
    if (e != 0 && !mFlag) begin mFlag = 1; mCode = e; end
    check(violFlag == mFlag && violCode == 4'(mCode), (e != 0) ? reqOf(e) : "R11",
          violCode, mCode);
    modelUpdate(op, b, ap);
    cyc++;
    @(negedge clk);
    cmdOp = 3'd0; cmdAutoPre = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0);
  endtask

  task automatic expectCode(input int code, input string req);
    check(violCode == 4'(code), req, violCode, code);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL R13 watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int op, r;
    cRCD = ck(15000); cRP = ck(15000); cWR = ck(15000); cRTP = ck(7500);
    cRRD = ck(FAST ? 7500 : 10000); cWTR = ck(FAST ? 7500 : 10000);
    void'($urandom(32'h1d2e3f));
    @(negedge clk);

    // R2 early and at limit
    doReset(); issue(1,0,0); idle(cRCD-2); issue(2,0,0); expectCode(1, "R2");
    doReset(); issue(1,0,0); idle(cRCD-1); issue(2,0,0); expectCode(0, "R13");
    // R3 reopen after close
    doReset(); issue(1,0,0); idle(cRCD+2); issue(4,0,0); idle(cRP-2); issue(1,0,0);
    expectCode(2, "R3");
    doReset(); issue(1,0,0); idle(cRCD+2); issue(4,0,0); idle(cRP-1); issue(1,0,0);
    expectCode(0, "R13");
    // R4 cross-bank open
    doReset(); issue(1,0,0); idle(cRRD-2); issue(1,1,0); expectCode(3, "R4");
    doReset(); issue(1,0,0); idle(cRRD-1); issue(1,1,0); expectCode(0, "R4");
    // R5 column spacing
    doReset(); issue(1,0,0); idle(cRRD); issue(1,1,0); idle(cRCD);
    issue(2,0,0); issue(2,1,0); expectCode(4, "R5");
    // R6 write recovery
    doReset(); issue(1,0,0); idle(cRCD-1); issue(3,0,0); idle(WD+cWR-2); issue(4,0,0);
    expectCode(5, "R6");
    // R7 write to read
    doReset(); issue(1,0,0); idle(cRCD-1); issue(3,0,0); idle(WD+cWTR-2); issue(2,0,0);
    expectCode(6, "R7");
    // R8 read to close
    doReset(); issue(1,0,0); idle(cRCD-1); issue(2,0,0); idle(cRTP-2); issue(4,0,0);
    expectCode(7, "R8");
    // R9 write with auto-close then reopen
    doReset(); issue(1,0,0); idle(cRCD-1); issue(3,0,1); idle(WD+cWR+cRP-2); issue(1,0,0);
    expectCode(8, "R9");
    doReset(); issue(1,0,0); idle(cRCD-1); issue(3,0,1); idle(WD+cWR+cRP-1); issue(1,0,0);
    expectCode(0, "R9");
    // R10 state errors, and ignored close of a closed bank
    doReset(); issue(4,2,0); expectCode(0, "R10"); issue(2,2,0); expectCode(9, "R10");
    doReset(); issue(1,0,0); idle(3); issue(1,0,0); expectCode(9, "R10");
    // R12 priority: column spacing beats turnaround
    doReset(); issue(1,0,0); idle(cRCD-1); issue(3,0,0); issue(2,0,0); expectCode(4, "R12");
    // R12 state error beats timing: read to closed bank right after a column
    doReset(); issue(1,0,0); idle(cRCD-1); issue(2,0,0); issue(2,1,0); expectCode(9, "R12");
    // R11 sticky code, repeated pulse
    doReset(); issue(1,0,0); idle(cRCD-2); issue(2,0,0); issue(2,0,0);
    expectCode(1, "R11"); issue(0,0,0);
    check(violPulse == 1'b0, "R11", violPulse, 0);

    // random streams
    for (int round = 0; round < 12; round++) begin
      doReset();
      for (int k = 0; k < 80; k++) begin
        r = int'($urandom_range(99));
        if (r < 30) op = 0;
        else if (r < 50) op = 1;
        else if (r < 65) op = 2;
        else if (r < 80) op = 3;
        else if (r < 95) op = 4;
        else op = 5;
        issue(op, int'($urandom_range(NB-1)), ($urandom_range(3) == 0));
      end
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule